// File: doc/BRIEF.md
# Tiled Fixed-Point Matrix Multiply Engine

This engine multiplies an n×m matrix A by an m×p matrix B and stores the n×p product C in a shared external memory. Software places A and B in memory, drives the three sizes and pulses a start input. The engine then sweeps the output in square blocks of T×T elements. For each block it runs a series of phases. In each phase it pulls one T×T slice of A and one T×T slice of B into small local buffers. It then performs T multiply-accumulate steps into a T×T array of accumulators. When the last phase of a block ends, it writes back the accumulators that land inside C.

Elements that a slice would take from outside A or B are filled with zero inside the engine. This makes sizes that are not multiples of T work without any special handling in the compute step. Operands are signed integers of DW bits. Each accumulator has room for the largest allowed inner dimension, so C is written at full accumulator width.

The memory port carries one access at a time. A write is a single-cycle request with the write flag set. A read is a single-cycle request, and its answer comes back on a valid strobe after any number of cycles.

Top module: `tiled_matmul`

## Requirements
- R1: start is accepted only while busy is low. busy goes high on the next cycle and stays high until done has pulsed for exactly one cycle. busy is low on the cycle after done.
- R2: A is row-major at address 0, so element (r,c) of A is read from address r·m + c.
- R3: B is row-major at address B_BASE, so element (r,c) of B is read from address B_BASE + r·p + c.
- R4: A slice element whose row or column falls outside its matrix is loaded as zero without any memory read. The read count is therefore exactly the number of in-range slice elements.
- R5: Every output block runs ceil(m/T) phases. Each phase loads both slices completely before its T accumulate steps, and it finishes those steps before the next load begins.
- R6: Each C element (r,c) with r < n and c < p is written exactly once, at C_BASE + r·p + c, with the exact signed sum over k of A(r,k)·B(k,c). No other address is written.
- R7: Output blocks are visited in row-major block order, and the elements inside a block are written in row-major order.
- R8: The accumulators hold 2·DW + clog2(MAXDIM+1) bits, so m = MAXDIM products of the most negative operand do not overflow.
- R9: At most one read is in flight: the engine issues no request while it waits for a read answer.
- R10: n, m and p are captured on the accepted start. Start pulses and size changes while busy have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a multiply when idle |
| n_in | input | DIMW | Rows of A and C |
| m_in | input | DIMW | Columns of A, rows of B (at least 1) |
| p_in | input | DIMW | Columns of B and C |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle pulse at job end |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | ACW | Write data (C element) |
| mem_rvalid | input | 1 | Read answer valid |
| mem_rdata | input | DW | Read answer data (A or B element) |

## Verification
A wrong slice index, a stale accumulator or a missing zero fill appears as a wrong C value. The error shows on the write bus in the very block where it happens, at the end of that block's last phase. A mistake in block sequencing appears as an out-of-order or duplicated write address. Skipped zero suppression appears at once as an extra read, or as a read address outside the live A or B region. Sweeping all small size combinations around T and its multiples exercises every partial-block shape, and an extreme-value job checks the accumulator headroom.

// File: rtl/tiled_matmul.sv
module tiled_matmul #(
  parameter int T = 2,
  parameter int DW = 8,
  parameter int MAXDIM = 8,
  parameter int AW = 8,
  parameter int B_BASE = 64,
  parameter int C_BASE = 128,
  localparam int DIMW = $clog2(MAXDIM + 1),
  localparam int ACW = 2 * DW + DIMW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [DIMW-1:0] n_in,
  input  logic [DIMW-1:0] m_in,
  input  logic [DIMW-1:0] p_in,
  output logic            busy,
  output logic            done,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [ACW-1:0]  mem_wdata,
  input  logic            mem_rvalid,
  input  logic [DW-1:0]   mem_rdata
);
  localparam int TT  = T * T;
  localparam int LIW = $clog2(2 * TT) + 1;
  localparam int WIW = $clog2(TT) + 1;
  localparam int KW  = $clog2(T) + 1;

  typedef enum logic [2:0] {S_IDLE, S_LREQ, S_LWAIT, S_COMP, S_WR, S_DONE} state_t;
  state_t st;

  logic [DIMW-1:0] n_r, m_r, p_r, ntr, ntc, nph, tr, tc, ph;
  logic [LIW-1:0]  li;
  logic [KW-1:0]   k;
  logic [WIW-1:0]  wi;
  logic signed [DW-1:0]    a_buf [TT];
  logic signed [DW-1:0]    b_buf [TT];
  logic signed [ACW-1:0]   acc   [TT];
  logic signed [2*DW-1:0]  prod  [TT];

  logic ld_isb, ld_inr, wr_inr;
  int   ld_idx, ld_addr, wr_addr;

  always_comb begin
    int ty, tx, row, col, wrow, wcol;
    ld_isb = int'(li) >= TT;
    ld_idx = ld_isb ? int'(li) - TT : int'(li);
    ty = ld_idx / T;
    tx = ld_idx % T;
    if (!ld_isb) begin
      row = int'(tr) * T + ty;
      col = int'(ph) * T + tx;
      ld_inr  = row < int'(n_r) && col < int'(m_r);
      ld_addr = row * int'(m_r) + col;
    end else begin
      row = int'(ph) * T + ty;
      col = int'(tc) * T + tx;
      ld_inr  = row < int'(m_r) && col < int'(p_r);
      ld_addr = B_BASE + row * int'(p_r) + col;
    end
    wrow = int'(tr) * T + int'(wi) / T;
    wcol = int'(tc) * T + int'(wi) % T;
    wr_inr  = wrow < int'(n_r) && wcol < int'(p_r);
    wr_addr = C_BASE + wrow * int'(p_r) + wcol;
  end

  always_comb begin
    for (int i = 0; i < T; i++)
      for (int j = 0; j < T; j++)
        prod[i*T+j] = a_buf[i*T+int'(k)] * b_buf[int'(k)*T+j];
  end

  assign busy      = st != S_IDLE;
  assign done      = st == S_DONE;
  assign mem_we    = st == S_WR;
  assign mem_req   = (st == S_LREQ && ld_inr) || (st == S_WR && wr_inr);
  assign mem_addr  = mem_we ? AW'(wr_addr) : AW'(ld_addr);
  assign mem_wdata = acc[int'(wi)];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      {n_r, m_r, p_r, ntr, ntc, nph, tr, tc, ph} <= '0;
      li <= '0;
      k  <= '0;
      wi <= '0;
      for (int i = 0; i < TT; i++) begin
        a_buf[i] <= '0;
        b_buf[i] <= '0;
        acc[i]   <= '0;
      end
    end else begin
      case (st)
        S_IDLE: if (start) begin
          n_r <= n_in;
          m_r <= m_in;
          p_r <= p_in;
          ntr <= DIMW'((int'(n_in) + T - 1) / T);
          ntc <= DIMW'((int'(p_in) + T - 1) / T);
          nph <= DIMW'((int'(m_in) + T - 1) / T);
          tr <= '0;
          tc <= '0;
          ph <= '0;
          li <= '0;
          for (int i = 0; i < TT; i++) acc[i] <= '0;
          st <= S_LREQ;
        end
        S_LREQ, S_LWAIT: begin
          if ((st == S_LREQ && !ld_inr) || (st == S_LWAIT && mem_rvalid)) begin
            if (ld_isb) b_buf[ld_idx] <= (st == S_LWAIT) ? $signed(mem_rdata) : '0;
            else        a_buf[ld_idx] <= (st == S_LWAIT) ? $signed(mem_rdata) : '0;
            if (li == LIW'(2 * TT - 1)) begin
              k  <= '0;
              st <= S_COMP;
            end else begin
              li <= li + 1'b1;
              st <= S_LREQ;
            end
          end else if (st == S_LREQ) begin
            st <= S_LWAIT;
          end
        end
        S_COMP: begin
          for (int i = 0; i < TT; i++) acc[i] <= acc[i] + ACW'(prod[i]);
          if (k == KW'(T - 1)) begin
            li <= '0;
            if (ph == nph - 1'b1) begin
              wi <= '0;
              st <= S_WR;
            end else begin
              ph <= ph + 1'b1;
              st <= S_LREQ;
            end
          end else begin
            k <= k + 1'b1;
          end
        end
        S_WR: begin
          if (wi == WIW'(TT - 1)) begin
            for (int i = 0; i < TT; i++) acc[i] <= '0;
            ph <= '0;
            li <= '0;
            st <= S_LREQ;
            if (tc == ntc - 1'b1) begin
              tc <= '0;
              if (tr == ntr - 1'b1) st <= S_DONE;
              else tr <= tr + 1'b1;
            end else begin
              tc <= tc + 1'b1;
            end
          end else begin
            wi <= wi + 1'b1;
          end
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  assert_start_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_read_region_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (int'(mem_addr) < C_BASE));
  assert_write_region_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (int'(mem_addr) >= C_BASE));
  assert_phase_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (ph < nph));
  assert_hold_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LWAIT && !mem_rvalid) |=> (st == S_LWAIT && !mem_req));
  assert_sizes_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(n_r) && $stable(m_r) && $stable(p_r)));
endmodule

// File: tb/tiled_matmul_bench.sv
`timescale 1ns/1ps
module tiled_matmul_bench;
  localparam int T = 2, DW = 8, MAXDIM = 8, AW = 8, BB = 64, CB = 128;
  localparam int DIMW = $clog2(MAXDIM + 1);
  localparam int ACW = 2 * DW + DIMW;

  logic clk = 0, rst_n = 0, start = 0;
  logic [DIMW-1:0] n_in = '0, m_in = '0, p_in = '0;
  logic busy, done, mem_req, mem_we, mem_rvalid = 0;
  logic [AW-1:0] mem_addr;
  logic [ACW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;

  tiled_matmul #(.T(T), .DW(DW), .MAXDIM(MAXDIM), .AW(AW), .B_BASE(BB), .C_BASE(CB)) u_tiled_matmul (
    .clk(clk), .rst_n(rst_n), .start(start), .n_in(n_in), .m_in(m_in), .p_in(p_in),
    .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata));

  always #4 clk = ~clk;

  int mem [256];
  int nchk = 0, nfail = 0;
  int reads = 0, writes = 0, bad_rd = 0;
  int wlog [64];
  int cur_n = 1, cur_m = 1, cur_p = 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin : memory_model
    bit pend = 0;
    int cnt = 0, ra = 0;
    forever begin
      @(negedge clk);
      mem_rvalid = 0;
      if (pend) begin
        if (cnt == 0) begin
          mem_rvalid = 1;
          mem_rdata = mem[ra][DW-1:0];
          pend = 0;
        end else cnt--;
      end else if (mem_req && !mem_we) begin
        ra = int'(mem_addr);
        if (!((ra < cur_n * cur_m) || (ra >= BB && ra < BB + cur_m * cur_p))) bad_rd++;
        pend = 1;
        cnt = reads % 3;
        reads++;
      end
      if (mem_req && mem_we) begin
        mem[int'(mem_addr)] = int'($signed(mem_wdata));
        if (writes < 64) wlog[writes] = int'(mem_addr);
        writes++;
      end
    end
  end

  task automatic run_job(input int n, input int m, input int p, input int mode, input bit poke);
    int exp_rd, idx, to, s;
    cur_n = n; cur_m = m; cur_p = p;
    for (int i = 0; i < 256; i++) mem[i] = -99999;
    for (int i = 0; i < n * m; i++) mem[i] = (mode == 1) ? -128 : ((i * 7 + n + 3) % 23) - 11;
    for (int i = 0; i < m * p; i++) mem[BB + i] = (mode == 1) ? -128 : ((i * 5 + p + 1) % 19) - 9;
    reads = 0; writes = 0; bad_rd = 0;
    @(negedge clk);
    n_in = DIMW'(n); m_in = DIMW'(m); p_in = DIMW'(p); start = 1;
    @(negedge clk);
    start = 0;
    chk(busy === 1'b1, "R1 busy after start", int'(busy), 1);
    to = 0;
    while (done !== 1'b1 && to < 20000) begin
      if (poke && to == 10) begin
        start = 1; n_in = 1; m_in = 1; p_in = 1;
      end
      if (poke && to == 11) begin
        start = 0; n_in = DIMW'(n); m_in = DIMW'(m); p_in = DIMW'(p);
      end
      @(negedge clk);
      to++;
    end
    start = 0;
    chk(to < 20000, "R1 done reached", to, 0);
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R1 idle after done", int'({busy, done}), 0);
    for (int r = 0; r < n; r++)
      for (int c = 0; c < p; c++) begin
        s = 0;
        for (int kk = 0; kk < m; kk++) s += mem[r * m + kk] * mem[BB + kk * p + c];
        chk(mem[CB + r * p + c] == s, poke ? "R10 value with start while busy" :
            (mode == 1 ? "R8 extreme value" : "R5 R6 product value"), mem[CB + r * p + c], s);
      end
    chk(writes == n * p, "R6 write count", writes, n * p);
    chk(mem[CB + n * p] == -99999, "R6 no write past C", mem[CB + n * p], -99999);
    exp_rd = 0;
    for (int tr = 0; tr < (n + T - 1) / T; tr++)
      for (int tc = 0; tc < (p + T - 1) / T; tc++)
        for (int ph = 0; ph < (m + T - 1) / T; ph++)
          for (int ty = 0; ty < T; ty++)
            for (int tx = 0; tx < T; tx++) begin
              if (tr * T + ty < n && ph * T + tx < m) exp_rd++;
              if (ph * T + ty < m && tc * T + tx < p) exp_rd++;
            end
    chk(reads == exp_rd, "R4 read count", reads, exp_rd);
    chk(bad_rd == 0, "R2 R3 read address range", bad_rd, 0);
    idx = 0;
    for (int tr = 0; tr < (n + T - 1) / T; tr++)
      for (int tc = 0; tc < (p + T - 1) / T; tc++)
        for (int ty = 0; ty < T; ty++)
          for (int tx = 0; tx < T; tx++)
            if (tr * T + ty < n && tc * T + tx < p) begin
              if (idx < writes && idx < 64)
                chk(wlog[idx] == CB + (tr * T + ty) * p + tc * T + tx, "R7 write order",
                    wlog[idx], CB + (tr * T + ty) * p + tc * T + tx);
              idx++;
            end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin : main
    int sz [4] = '{1, 2, 3, 5};
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && mem_req === 1'b0, "R1 reset state",
        int'({busy, done, mem_req}), 0);
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          run_job(sz[a], sz[b], sz[c], 0, 1'b0);
    run_job(4, 6, 3, 0, 1'b0);
    run_job(1, MAXDIM, 1, 1, 1'b0);
    run_job(3, MAXDIM, 3, 1, 1'b0);
    run_job(3, 4, 5, 0, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule